// File: doc/BRIEF.md
# Block-Cipher-Mode DMA Trigger Sequencer

This block sits beside a 128-bit cipher core. It lets a DMA engine move data through the core one 16-bit half-word at a time. It watches the core-done pulse and the accesses the DMA makes to the core's data registers. From these it raises three trigger lines in the order the selected chaining mode needs, so the DMA can run ECB, CBC or OFB over many blocks without software stepping in.

Each 128-bit block is split into phases. A phase is eight half-word transfers aimed at one register: the data-output read port, the plain data-input write port, the XOR-then-start input write port, or the XOR-only input write port. After each expected access the trigger of that phase pulses again, until the eighth access. The next phase then starts. The chaining mode and the direction decide which register each phase targets and whether there are two phases or three. When the last phase ends, the block waits for the next core-done pulse.

Top module: `cmseq_top`

## Requirements
- R1: While `seq_en` is 0, every bit of `trig` stays 0 from the next clock on. Clearing `seq_en` in the middle of a sequence aborts it. The next enable starts fresh with a transfer count of zero.
- R2: `chain_sel` 2'b00 is ECB, 2'b01 is CBC, 2'b10 is OFB. `chain_sel` 2'b11 is reserved and raises no trigger. `op_sel` 2'b00 selects encryption and any other value selects decryption. `trig[k]` is trigger k.
- R3: Every trigger is a single-cycle pulse, and at most one bit of `trig` is high in any cycle. A phase is eight accesses. Each of the first seven expected accesses pulses the phase's trigger again one clock later.
- R4: In ECB (either direction), core done gives trigger 0 for eight output reads (`rd_dout`). Trigger 1 follows for eight plain input writes (`wr_din`). Trigger 2 never pulses.
- R5: In ECB, enabling the block pulses trigger 1 one clock later and opens the plain-input-write phase, so the first block can be loaded.
- R6: In CBC encryption, core done gives trigger 0 for eight output reads. Trigger 1 follows for eight XOR-then-start writes (`wr_xstart`). Trigger 2 never pulses.
- R7: In CBC decryption, core done gives trigger 0 for eight XOR-only writes (`wr_xonly`). Trigger 1 follows for eight output reads, then trigger 2 for eight plain input writes.
- R8: In OFB (either direction), core done gives trigger 0 for eight XOR-only writes. Trigger 1 follows for eight output reads, then trigger 2 for eight XOR-then-start writes.
- R9: An access to a register other than the current phase's target has no effect: no pulse, and the transfer count does not move. A core-done pulse during a phase is also ignored.
- R10: The eighth access of a phase pulses the next phase's trigger one clock later. The eighth access of the final phase pulses nothing, and the block then waits for core done. Core done pulses trigger 0 one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seq_en | input | 1 | Sequencer enable |
| chain_sel | input | 2 | Chaining-mode select |
| op_sel | input | 2 | Direction select |
| core_done | input | 1 | Cipher core finished a block (one-cycle pulse) |
| rd_dout | input | 1 | Half-word read of the data-output register |
| wr_din | input | 1 | Half-word write to the plain data-input register |
| wr_xstart | input | 1 | Half-word write to the XOR-then-start input register |
| wr_xonly | input | 1 | Half-word write to the XOR-only input register |
| trig | output | 3 | Trigger pulses, bit k is trigger k |

## Verification
The assertions assume that `chain_sel` and `op_sel` only change while `seq_en` is 0. They also assume that the DMA strobes and core done are clean single-cycle pulses, synchronous to `clk`. The stimulus changes the mode only after it has dropped the enable. It raises each strobe for exactly one clock, with an idle clock between accesses, and it never raises two strobes at once. Non-target accesses and stray core-done pulses are injected on purpose in the middle of phases. This keeps them legal for the assertions while exercising the ignore rules.

// File: rtl/cmseq_pkg.sv
package cmseq_pkg;

  localparam int NUM_TRIG = 3;
  localparam int PH_W     = $clog2(NUM_TRIG);

  typedef enum logic [1:0] {
    CH_ECB = 2'b00,
    CH_CBC = 2'b01,
    CH_OFB = 2'b10,
    CH_RSV = 2'b11
  } chain_e;

  typedef enum logic [2:0] {
    ACC_NONE   = 3'd0,
    ACC_RD_OUT = 3'd1,
    ACC_WR_IN  = 3'd2,
    ACC_WR_XST = 3'd3,
    ACC_WR_XOR = 3'd4
  } acc_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_XFER = 2'd2
  } state_e;

  typedef logic [PH_W-1:0] phase_t;

endpackage

// File: rtl/cmseq_plan.sv
module cmseq_plan
  import cmseq_pkg::*;
(
  input  logic [1:0] chain_sel,
  input  logic [1:0] op_sel,
  input  phase_t     phase_i,
  output acc_e       target_o,
  output phase_t     last_phase_o,
  output logic       mode_ok_o,
  output logic       preload_o
);

  logic decrypt;
  assign decrypt = (op_sel != 2'b00);

  always_comb begin
    target_o     = ACC_NONE;
    last_phase_o = phase_t'(1);
    mode_ok_o    = 1'b1;
    preload_o    = 1'b0;
    case (chain_e'(chain_sel))
      CH_ECB: begin
        preload_o = 1'b1;
        case (phase_i)
          phase_t'(0): target_o = ACC_RD_OUT;
          phase_t'(1): target_o = ACC_WR_IN;
          default:     target_o = ACC_NONE;
        endcase
      end
      CH_CBC: begin
        if (!decrypt) begin
          case (phase_i)
            phase_t'(0): target_o = ACC_RD_OUT;
            phase_t'(1): target_o = ACC_WR_XST;
            default:     target_o = ACC_NONE;
          endcase
        end else begin
          last_phase_o = phase_t'(2);
          case (phase_i)
            phase_t'(0): target_o = ACC_WR_XOR;
            phase_t'(1): target_o = ACC_RD_OUT;
            phase_t'(2): target_o = ACC_WR_IN;
            default:     target_o = ACC_NONE;
          endcase
        end
      end
      CH_OFB: begin
        last_phase_o = phase_t'(2);
        case (phase_i)
          phase_t'(0): target_o = ACC_WR_XOR;
          phase_t'(1): target_o = ACC_RD_OUT;
          phase_t'(2): target_o = ACC_WR_XST;
          default:     target_o = ACC_NONE;
        endcase
      end
      default: begin
        mode_ok_o = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/cmseq_match.sv
module cmseq_match
  import cmseq_pkg::*;
(
  input  acc_e target_i,
  input  logic rd_dout,
  input  logic wr_din,
  input  logic wr_xstart,
  input  logic wr_xonly,
  output logic hit_o
);

  always_comb begin
    case (target_i)
      ACC_RD_OUT: hit_o = rd_dout;
      ACC_WR_IN:  hit_o = wr_din;
      ACC_WR_XST: hit_o = wr_xstart;
      ACC_WR_XOR: hit_o = wr_xonly;
      default:    hit_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/cmseq_xfer_cnt.sv
module cmseq_xfer_cnt #(
  parameter int XFERS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);

  localparam int CW = (XFERS > 1) ? $clog2(XFERS) : 1;
  localparam logic [CW-1:0] LAST_VAL = CW'(XFERS - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign cnt_en = clr_i | inc_i;

  always_comb begin
    if (clr_i) cnt_d = '0;
    else       cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last_o = (cnt_q == LAST_VAL);

  // R3: the count never steps past the last transfer of a phase
  a_r3_cnt_no_wrap_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !clr_i) |-> !last_o);

endmodule

// File: rtl/cmseq_top.sv
module cmseq_top
  import cmseq_pkg::*;
#(
  parameter int XFERS_PER_PHASE = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       seq_en,
  input  logic [1:0] chain_sel,
  input  logic [1:0] op_sel,
  input  logic       core_done,
  input  logic       rd_dout,
  input  logic       wr_din,
  input  logic       wr_xstart,
  input  logic       wr_xonly,
  output logic [2:0] trig
);

  state_e st_q, st_d;
  phase_t ph_q, ph_d;
  logic   st_en;

  acc_e   target;
  phase_t last_phase;
  logic   mode_ok, preload, hit, cnt_last;
  logic   cnt_clr, cnt_inc;
  logic   fire;
  phase_t fire_idx;
  logic [NUM_TRIG-1:0] trig_q;

  cmseq_plan u_plan (
    .chain_sel    (chain_sel),
    .op_sel       (op_sel),
    .phase_i      (ph_q),
    .target_o     (target),
    .last_phase_o (last_phase),
    .mode_ok_o    (mode_ok),
    .preload_o    (preload)
  );

  cmseq_match u_match (
    .target_i  (target),
    .rd_dout   (rd_dout),
    .wr_din    (wr_din),
    .wr_xstart (wr_xstart),
    .wr_xonly  (wr_xonly),
    .hit_o     (hit)
  );

  cmseq_xfer_cnt #(.XFERS(XFERS_PER_PHASE)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (cnt_clr),
    .inc_i  (cnt_inc),
    .last_o (cnt_last)
  );

  // next-state
  always_comb begin
    st_d     = st_q;
    ph_d     = ph_q;
    cnt_clr  = 1'b0;
    cnt_inc  = 1'b0;
    fire     = 1'b0;
    fire_idx = phase_t'(0);
    if (!seq_en || !mode_ok) begin
      st_d    = ST_IDLE;
      cnt_clr = 1'b1;
    end else begin
      case (st_q)
        ST_IDLE: begin
          cnt_clr = 1'b1;
          if (preload) begin
            st_d     = ST_XFER;
            ph_d     = phase_t'(1);
            fire     = 1'b1;
            fire_idx = phase_t'(1);
          end else begin
            st_d = ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (core_done) begin
            st_d     = ST_XFER;
            ph_d     = phase_t'(0);
            cnt_clr  = 1'b1;
            fire     = 1'b1;
            fire_idx = phase_t'(0);
          end
        end
        ST_XFER: begin
          if (hit) begin
            if (!cnt_last) begin
              cnt_inc  = 1'b1;
              fire     = 1'b1;
              fire_idx = ph_q;
            end else if (ph_q == last_phase) begin
              st_d    = ST_WAIT;
              cnt_clr = 1'b1;
            end else begin
              ph_d     = ph_q + phase_t'(1);
              cnt_clr  = 1'b1;
              fire     = 1'b1;
              fire_idx = ph_q + phase_t'(1);
            end
          end
        end
        default: begin
          st_d    = ST_IDLE;
          cnt_clr = 1'b1;
        end
      endcase
    end
  end

  assign st_en = (st_d != st_q) || (ph_d != ph_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      ph_q <= phase_t'(0);
    end else if (st_en) begin
      st_q <= st_d;
      ph_q <= ph_d;
    end
  end

  for (genvar k = 0; k < NUM_TRIG; k++) begin : g_trig
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) trig_q[k] <= 1'b0;
      else        trig_q[k] <= fire && (fire_idx == phase_t'(k));
    end
  end

  assign trig = trig_q;

  // R1: disabled sequencer is silent on the next clock
  a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_en |=> (trig == 3'b000));

  // R3: never two triggers at once
  a_r3_one_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(trig));

  // R4, R6: two-phase modes never reach trigger 2
  a_r4_no_third_trig: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_en && (chain_sel == 2'b00 || (chain_sel == 2'b01 && op_sel == 2'b00)))
      |=> !trig[2]);

  // R5: ECB enable preloads with trigger 1
  a_r5_ecb_preload: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(seq_en) && chain_sel == 2'b00) |=> (trig == 3'b010));

  // R10: trigger 0 only follows core done or a DMA access
  a_r10_trig0_cause: assert property (@(posedge clk) disable iff (!rst_n)
    trig[0] |-> $past(core_done || rd_dout || wr_din || wr_xstart || wr_xonly));

  // R2: reserved mode stays silent
  a_r2_reserved_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_sel == 2'b11) |=> (trig == 3'b000));

endmodule

// File: tb/test_cmseq_top.sv
module test_cmseq_top;

  localparam int K_NONE = 0, K_RD = 1, K_DIN = 2, K_XST = 3, K_XOR = 4, K_DONE = 5;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       seq_en, core_done, rd_dout, wr_din, wr_xstart, wr_xonly;
  logic [1:0] chain_sel, op_sel;
  logic [2:0] trig;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  typedef struct { int idx; string req; } exp_t;
  exp_t exp_q[$];

  cmseq_top i_cmseq_top (
    .clk(clk), .rst_n(rst_n), .seq_en(seq_en), .chain_sel(chain_sel),
    .op_sel(op_sel), .core_done(core_done), .rd_dout(rd_dout), .wr_din(wr_din),
    .wr_xstart(wr_xstart), .wr_xonly(wr_xonly), .trig(trig)
  );

  always #5 clk = ~clk;

  // monitor: pop and compare each observed trigger
  always @(negedge clk) begin
    if (rst_n === 1'b1 && trig !== 3'b000) begin
      vectors++;
      if (exp_q.size() == 0) begin
        miscompares++;
        $display("FAIL unexpected trigger: actual %b expected 000", trig);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (trig !== (3'b001 << e.idx)) begin
          miscompares++;
          $display("FAIL %s: actual %b expected %b", e.req, trig, 3'b001 << e.idx);
        end
      end
    end
  end

  task automatic finish_step(input int exp, input string req);
    @(negedge clk);
    rd_dout = 0; wr_din = 0; wr_xstart = 0; wr_xonly = 0; core_done = 0;
    #1;
    vectors++;
    if (exp >= 0) begin
      if (exp_q.size() != 0) begin
        miscompares++;
        $display("FAIL %s: actual no trigger expected trig[%0d]", req, exp);
        exp_q.delete();
      end
    end else if (trig !== 3'b000) begin
      miscompares++;
      $display("FAIL %s: actual %b expected 000", req, trig);
    end
  endtask

  task automatic step(input int kind, input int exp, input string req);
    @(negedge clk);
    case (kind)
      K_RD:   rd_dout = 1;
      K_DIN:  wr_din = 1;
      K_XST:  wr_xstart = 1;
      K_XOR:  wr_xonly = 1;
      K_DONE: core_done = 1;
      default: ;
    endcase
    if (exp >= 0) exp_q.push_back('{exp, req});
    finish_step(exp, req);
  endtask

  task automatic set_en(input logic v, input int exp, input string req);
    @(negedge clk);
    seq_en = v;
    if (exp >= 0) exp_q.push_back('{exp, req});
    finish_step(exp, req);
  endtask

  // eight accesses; first seven re-raise tid, eighth gives last_exp
  task automatic phase(input int kind, input int tid, input int last_exp, input string req);
    for (int i = 0; i < 8; i++) step(kind, (i < 7) ? tid : last_exp, req);
  endtask

  task automatic mode(input logic [1:0] c, input logic [1:0] o);
    @(negedge clk);
    chain_sel = c; op_sel = o;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst_n = 0; seq_en = 0; chain_sel = 2'b00; op_sel = 2'b00;
    core_done = 0; rd_dout = 0; wr_din = 0; wr_xstart = 0; wr_xonly = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    vectors++;
    if (trig !== 3'b000) begin
      miscompares++;
      $display("FAIL R1 reset: actual %b expected 000", trig);
    end

    // R1: disabled, nothing fires
    step(K_DONE, -1, "R1");
    step(K_RD, -1, "R1");

    // R4/R5: ECB encryption
    mode(2'b00, 2'b00);
    set_en(1, 1, "R5");
    phase(K_DIN, 1, -1, "R4");
    step(K_DONE, 0, "R10");
    for (int i = 0; i < 3; i++) step(K_RD, 0, "R4");
    step(K_XOR, -1, "R9");   // wrong register
    step(K_DIN, -1, "R9");
    step(K_DONE, -1, "R9");  // done mid-phase
    for (int i = 3; i < 7; i++) step(K_RD, 0, "R9");
    step(K_RD, 1, "R10");
    phase(K_DIN, 1, -1, "R4");
    step(K_RD, -1, "R10");   // waiting for done

    // R4: ECB decryption
    set_en(0, -1, "R1");
    mode(2'b00, 2'b01);
    set_en(1, 1, "R5");
    phase(K_DIN, 1, -1, "R4");
    step(K_DONE, 0, "R4");
    phase(K_RD, 0, 1, "R4");
    phase(K_DIN, 1, -1, "R4");

    // R6: CBC encryption
    set_en(0, -1, "R1");
    mode(2'b01, 2'b00);
    set_en(1, -1, "R6");
    step(K_RD, -1, "R6");
    step(K_DONE, 0, "R6");
    phase(K_RD, 0, 1, "R6");
    step(K_DIN, -1, "R9");
    phase(K_XST, 1, -1, "R6");

    // R7: CBC decryption, op 11
    set_en(0, -1, "R1");
    mode(2'b01, 2'b11);
    set_en(1, -1, "R7");
    step(K_DONE, 0, "R7");
    phase(K_XOR, 0, 1, "R7");
    phase(K_RD, 1, 2, "R7");
    step(K_XST, -1, "R9");
    phase(K_DIN, 2, -1, "R7");

    // R8: OFB encryption and decryption
    set_en(0, -1, "R1");
    mode(2'b10, 2'b00);
    set_en(1, -1, "R8");
    step(K_DONE, 0, "R8");
    phase(K_XOR, 0, 1, "R8");
    phase(K_RD, 1, 2, "R8");
    phase(K_XST, 2, -1, "R8");
    set_en(0, -1, "R1");
    mode(2'b10, 2'b01);
    set_en(1, -1, "R8");
    step(K_DONE, 0, "R8");
    phase(K_XOR, 0, 1, "R8");
    phase(K_RD, 1, 2, "R8");
    phase(K_XST, 2, -1, "R8");

    // R2: reserved mode
    set_en(0, -1, "R1");
    mode(2'b11, 2'b00);
    set_en(1, -1, "R2");
    step(K_DONE, -1, "R2");
    step(K_DIN, -1, "R2");
    step(K_RD, -1, "R2");

    // R1: abort and restart
    set_en(0, -1, "R1");
    mode(2'b01, 2'b00);
    set_en(1, -1, "R1");
    step(K_DONE, 0, "R1");
    for (int i = 0; i < 3; i++) step(K_RD, 0, "R1");
    set_en(0, -1, "R1");
    step(K_RD, -1, "R1");
    step(K_DONE, -1, "R1");
    set_en(1, -1, "R1");
    step(K_DONE, 0, "R1");
    phase(K_RD, 0, 1, "R1");
    phase(K_XST, 1, -1, "R1");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule